// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked on-chip request port and an external asynchronous static RAM. The RAM has a 15-bit word address and an 8-bit data path. The block takes one single-word read or write at a time through a valid/ready handshake. It then produces the active-low select, write-strobe and output-enable waveforms the memory expects. Every setup, strobe and access interval is a whole number of clock cycles, computed from a clock-period parameter and picosecond timing parameters.

The memory's data pins are shared in both directions. At the block edge they appear as three signals: a driven value, a drive enable and a sampled input. The pad cell lives elsewhere. A write strobe is the span where select and write-strobe are both low, and it ends with the write-strobe rising. The driven data is held through one more cycle after that edge. A read holds select and output-enable low for the access time and then samples the bus. It returns the byte with a one-cycle valid strobe. A turnaround gap with the memory deselected lets it release the bus before the controller drives it again.

The state machine has six states:
- `ST_IDLE`: deselected and ready. An accepted write goes to `ST_WSETUP` and an accepted read goes to `ST_RACCESS`.
- `ST_WSETUP`: always moves to `ST_WPULSE`.
- `ST_WPULSE`: moves to `ST_WHOLD` when its counter expires.
- `ST_WHOLD`: returns to `ST_IDLE`.
- `ST_RACCESS`: samples the bus when its counter expires and moves to `ST_RTURN`.
- `ST_RTURN`: returns to `ST_IDLE` when its counter expires.

Top module: `asram_ctl`

## Requirements
- R1: While idle, and from reset, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and req_ready is 1.
- R2: In the first cycle after a write is accepted, mem_ce_n is 0, mem_we_n is 1 and mem_oe_n is 1, with the request address on mem_addr and the write byte driven (mem_dq_oe 1).
- R3: mem_we_n is then 0 for exactly PULSE cycles, where PULSE is the larger of ceil(T_WP_PS/CLK_PS) and ceil(T_DS_PS/CLK_PS). During those cycles mem_ce_n stays 0 and the address and driven data do not change.
- R4: In the cycle after mem_we_n rises, mem_ce_n is still 0 and the same byte is still driven. In the cycle after that the block is idle again.
- R5: A read of an address returns the byte most recently written there on rsp_rdata.
- R6: After a read is accepted, mem_ce_n and mem_oe_n are 0 and mem_we_n is 1 for exactly ACC = ceil(T_AA_PS/CLK_PS) cycles. rsp_valid is 1 for exactly the one cycle after the ACC-th clock edge that follows acceptance.
- R7: mem_dq_oe is 0 whenever mem_oe_n is 0, and it was already 0 in the cycle before.
- R8: After a read, mem_ce_n and mem_oe_n are 1 and req_ready is 0 for TURN = ceil(T_OHZ_PS/CLK_PS) cycles before the block is idle again.
- R9: A request is taken only at an edge where req_ready is 1. A request held during a busy transfer causes no memory access, and writes never raise rsp_valid.
- R10: mem_addr does not change while mem_ce_n stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_o | output | DATA_W | Value driven onto the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_i | input | DATA_W | Value sampled from the data pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The bench builds the block with ADDR_W = 6 and an 8000 ps clock, with the timing parameters at their defaults. This gives a one-cycle write strobe, a two-cycle read access and a one-cycle turnaround. The small address space lets every location be written, read back and rewritten with arithmetic patterns, including a read directly after a write to the same address. The bench's memory model delays valid read data by the access time. A read that samples one cycle early therefore returns wrong data.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACCESS,
        ST_RTURN
    } asram_state_e;

    // Whole clock cycles covering a time in picoseconds, never below one.
    function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_tcnt.sv
`timescale 1ns/1ps
// Down counter that times how long the controller stays in a state.
module asram_tcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_dq.sv
`timescale 1ns/1ps
// Request latch and read-data capture.
module asram_dq #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture)
                rdata_q <= mem_dq_i;
        end
    end
endmodule

// File: rtl/asram_ctl.sv
`timescale 1ns/1ps
module asram_ctl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 15,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_PS    = 8000,
    parameter int unsigned T_WP_PS   = 7000,   // minimum write-strobe width
    parameter int unsigned T_DS_PS   = 5000,   // data setup to strobe end
    parameter int unsigned T_AA_PS   = 10000,  // address/select to data valid
    parameter int unsigned T_OHZ_PS  = 5000    // output-enable high to bus release
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n
);
    localparam int unsigned PULSE_CYC = umax(ps_to_cyc(T_WP_PS, CLK_PS), ps_to_cyc(T_DS_PS, CLK_PS));
    localparam int unsigned ACC_CYC   = ps_to_cyc(T_AA_PS, CLK_PS);
    localparam int unsigned TURN_CYC  = ps_to_cyc(T_OHZ_PS, CLK_PS);
    localparam int unsigned MAX_CYC   = umax(PULSE_CYC, umax(ACC_CYC, TURN_CYC));
    localparam int unsigned CW        = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    asram_state_e state_q, state_d;
    logic          accept, capture;
    logic          cnt_load, cnt_done;
    logic [CW-1:0] cnt_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    asram_tcnt #(.W(CW)) tcnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    asram_dq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .mem_dq_i  (mem_dq_i),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rsp_rdata),
        .rvalid_q  (rsp_valid)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions and counter loads
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        capture  = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        state_d = ST_WSETUP;
                    end else begin
                        state_d  = ST_RACCESS;
                        cnt_load = 1'b1;
                        cnt_val  = CW'(ACC_CYC - 1);
                    end
                end
            end
            ST_WSETUP: begin
                state_d  = ST_WPULSE;
                cnt_load = 1'b1;
                cnt_val  = CW'(PULSE_CYC - 1);
            end
            ST_WPULSE: begin
                if (cnt_done)
                    state_d = ST_WHOLD;
            end
            ST_WHOLD: begin
                state_d = ST_IDLE;
            end
            ST_RACCESS: begin
                if (cnt_done) begin
                    capture  = 1'b1;
                    state_d  = ST_RTURN;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(TURN_CYC - 1);
                end
            end
            ST_RTURN: begin
                if (cnt_done)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Memory-side outputs decoded from the registered state
    always_comb begin
        req_ready = 1'b0;
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_WSETUP:  begin mem_ce_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WPULSE:  begin mem_ce_n = 1'b0; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WHOLD:   begin mem_ce_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_RACCESS: begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; end
            ST_RTURN:   ;
            default:    ;
        endcase
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;
endmodule

// File: rtl/asram_ctl_chk.sv
`timescale 1ns/1ps
module asram_ctl_chk #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_write_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_dq_oe) && $stable(mem_addr)));

    assert_strobe_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n));

    assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_dq_o) && $stable(mem_addr)));

    assert_rvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && $past(!mem_dq_oe)));

    assert_read_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (mem_ce_n && !req_ready));

    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind asram_ctl asram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n)
);

// File: tb/asram_ctl_tb_top.sv
`timescale 1ns/1ps
module asram_ctl_tb_top;
    localparam int AW     = 6;
    localparam int DW     = 8;
    localparam int CLKPS  = 8000;
    localparam int WP_PS  = 7000;
    localparam int DS_PS  = 5000;
    localparam int AA_PS  = 10000;
    localparam int OHZ_PS = 5000;
    localparam int NLOC   = 1 << AW;
    // Expected cycle counts, from the requirement formulas
    localparam int P_WP = (WP_PS + CLKPS - 1) / CLKPS;
    localparam int P_DS = (DS_PS + CLKPS - 1) / CLKPS;
    localparam int PULSE = (P_WP > P_DS) ? P_WP : P_DS;
    localparam int ACC   = (AA_PS + CLKPS - 1) / CLKPS;
    localparam int TURN  = (OHZ_PS + CLKPS - 1) / CLKPS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_o, mem_dq_i;
    logic mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;

    always #4 clk = ~clk;

    asram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLKPS), .T_WP_PS(WP_PS),
                .T_DS_PS(DS_PS), .T_AA_PS(AA_PS), .T_OHZ_PS(OHZ_PS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    // Memory model: write on the strobe's rising edge, read data valid 10 ns after select+enable
    logic [DW-1:0] sram [NLOC];
    int unsafe_writes = 0;
    logic rd_cond, rd_ok;
    assign rd_cond = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign #10 rd_ok = rd_cond;
    assign mem_dq_i = (rd_cond && rd_ok) ? sram[mem_addr] : ~sram[mem_addr];

    always @(posedge mem_we_n) begin
        if (!mem_ce_n) begin
            if (!mem_dq_oe) unsafe_writes++;
            sram[mem_addr] = mem_dq_o;
        end
    end
    always @(posedge mem_ce_n) begin
        if (!mem_we_n) begin
            if (!mem_dq_oe) unsafe_writes++;
            sram[mem_addr] = mem_dq_o;
        end
    end

    int n_chk = 0, n_fail = 0;
    int contention = 0;
    bit finished = 1'b0;
    logic prev_oe = 1'b0;

    always @(negedge clk) begin
        if (rst_n && !mem_oe_n && (mem_dq_oe || prev_oe)) contention++;
        prev_oe = mem_dq_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat1(input int a);
        return DW'((a * 29 + 7) & 8'hFF);
    endfunction
    function automatic logic [DW-1:0] pat2(input int a);
        return DW'(((a << 2) ^ 8'h5A ^ a) & 8'hFF);
    endfunction

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        bit ok;
        bit rv;
        wait_idle();
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        rv = rsp_valid;
        ok = !mem_ce_n && mem_we_n && mem_oe_n && mem_dq_oe && mem_addr == AW'(a) && mem_dq_o == d;
        check(ok, "R2 write setup", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0111);
        ok = 1'b1;
        for (int i = 0; i < PULSE; i++) begin
            @(negedge clk);
            rv |= rsp_valid;
            if (!(!mem_ce_n && !mem_we_n && mem_dq_oe && mem_dq_o == d && mem_addr == AW'(a))) ok = 1'b0;
        end
        check(ok, "R3 strobe width", int'(ok), 1);
        @(negedge clk);
        rv |= rsp_valid;
        ok = !mem_ce_n && mem_we_n && mem_dq_oe && mem_dq_o == d;
        check(ok, "R4 write hold", {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b011);
        @(negedge clk);
        rv |= rsp_valid;
        ok = mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready;
        check(ok, "R1 idle after write", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);
        check(!rv, "R9 no strobe on write", int'(rv), 0);
    endtask

    task automatic do_read(input int a, input logic [DW-1:0] exp);
        bit ok;
        wait_idle();
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < ACC; i++) begin
            if (i > 0) @(negedge clk);
            if (!(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid && !req_ready
                  && mem_addr == AW'(a))) ok = 1'b0;
        end
        check(ok, "R6 access window", int'(ok), 1);
        @(negedge clk);
        check(rsp_valid, "R6 strobe timing", int'(rsp_valid), 1);
        check(rsp_rdata == exp, "R5 read data", int'(rsp_rdata), int'(exp));
        ok = mem_ce_n && mem_oe_n && !req_ready;
        for (int i = 1; i < TURN; i++) begin
            @(negedge clk);
            if (!(mem_ce_n && mem_oe_n && !req_ready)) ok = 1'b0;
        end
        check(ok, "R8 turnaround", int'(ok), 1);
        @(negedge clk);
        check(!rsp_valid && req_ready, "R6/R8 single strobe then idle", {rsp_valid, req_ready}, 2'b01);
    endtask

    initial begin
        for (int i = 0; i < NLOC; i++) sram[i] = '0;
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
              "R1 reset state", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_ce_n, "R1 idle after reset", {req_ready, mem_ce_n}, 2'b11);

        // Sweep: fill every location, then read all back
        for (int a = 0; a < NLOC; a++) do_write(a, pat1(a));
        for (int a = 0; a < NLOC; a++) do_read(a, pat1(a));

        // Interleave: rewrite then read at once (write-to-read turnaround)
        for (int a = NLOC - 1; a >= 0; a--) begin
            do_write(a, pat2(a));
            do_read(a, pat2(a));
        end

        // R9: request held high while busy must not start a second access
        wait_idle();
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(3); req_wdata = 8'h3C;
        @(posedge clk);
        for (int i = 0; i < PULSE + 2; i++) begin
            @(negedge clk);
            req_addr = AW'(9); req_wdata = 8'hEE;
        end
        req_valid = 1'b0;
        @(negedge clk);
        check(req_ready, "R9 idle after held request", int'(req_ready), 1);
        do_read(9, pat2(9));
        do_read(3, 8'h3C);

        check(contention == 0, "R7 bus contention", contention, 0);
        check(unsafe_writes == 0, "R3 strobe without drive", unsafe_writes, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule